// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns the start column of a READ or WRITE into the column address for each cycle of a memory burst. A mode word sets the burst length and the column order. The length is 1, 2, 4 or 8 columns, or a full page. The order is either sequential (add and wrap) or interleaved (XOR). The block keeps the mode word it last accepted. Each burst latches that mode when it starts, so a later mode change does not alter a burst already running.

A fixed-length burst stays inside an aligned block of columns whose size is the burst length. The column bits above the block are taken from the start column. Only the low bits step, and they wrap at the block edge. A full-page burst steps through the 256-column page and wraps there. It runs until a terminate strobe arrives. A terminate strobe also cuts a fixed-length burst short.

A mode load is refused, and the error flag is raised, in either of two cases: some bank is busy, or the word uses an illegal length setting. After an accepted load, the block ignores further loads and burst starts for two clock cycles.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, col_valid_o, burst_done_o and load_err_o are 0. The stored mode is burst length 1 with sequential order.
- R2: A load is accepted and stored when mode_load_i is sampled high, banks_idle_i is 1, the length setting is legal and no guard window is open. An accepted load clears load_err_o on the next cycle. Mode bits [2:0] give the length: 000=1, 001=2, 010=4, 011=8, 111=full page. Bit 3 selects the order: 0 = sequential, 1 = interleaved. Bits [10:4] have no effect on sequencing.
- R3: A load sampled while banks_idle_i is 0 sets load_err_o on the next cycle and leaves the stored mode unchanged.
- R4: A load sampled with length code 100, 101 or 110, or with code 111 together with bit 3 = 1, sets load_err_o and leaves the stored mode unchanged.
- R5: On the two cycles after an accepted load, mode_load_i and start_i are ignored. Such a load neither changes the mode nor changes load_err_o.
- R6: In a sequential burst of length BL from start column S, beat k outputs (S & ~(BL-1)) | ((S + k) mod BL).
- R7: In an interleaved burst of length BL from start column S, beat k outputs (S & ~(BL-1)) | ((S ^ k) & (BL-1)).
- R8: A full-page burst outputs (S + k) mod 256 on beat k and continues until a terminate strobe.
- R9: When term_i is high during an active burst, burst_done_o is high in that same cycle. col_valid_o is 0 on the next cycle unless a new burst starts.
- R10: A fixed-length burst keeps col_valid_o high for exactly BL cycles, beginning the cycle after start_i is sampled. burst_done_o pulses on the last of those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_load_i | input | 1 | Mode load strobe |
| mode_val_i | input | 11 | Mode word to load |
| banks_idle_i | input | 1 | All banks idle |
| start_i | input | 1 | Burst start strobe |
| start_col_i | input | 8 | Burst start column |
| term_i | input | 1 | Terminate strobe |
| col_o | output | 8 | Current burst column |
| col_valid_o | output | 1 | col_o is a burst beat |
| burst_done_o | output | 1 | Last beat of the burst |
| load_err_o | output | 1 | Last load attempt was rejected |

## Verification
A start sampled at a rising edge makes its first beat visible right after that edge. Each following beat appears one edge later. A mode load shows its effect on load_err_o right after the edge that samples it. The guard window closes two edges after that, so a start driven on the third falling edge after the load is the first one accepted. burst_done_o depends on term_i without a register, so the bench drives term_i at a falling edge and samples after a short delay in the same half cycle. All other outputs are sampled at falling edges, using a beat index that the bench counts from its own start stimulus.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  function automatic logic len_legal(input logic [2:0] code, input logic ilv);
    case (code)
      LEN_1, LEN_2, LEN_4, LEN_8: len_legal = 1'b1;
      LEN_PAGE:                   len_legal = !ilv;
      default:                    len_legal = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bseq_mode_ctl.sv
module bseq_mode_ctl #(
  parameter int MODE_W    = 11,
  parameter int GUARD_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MODE_W-1:0] val_i,
  input  logic              idle_i,
  output logic [2:0]        len_o,
  output logic              ilv_o,
  output logic              busy_o,
  output logic              err_o
);
  import burst_seq_pkg::*;
  localparam int GW = $clog2(GUARD_CYC + 1);

  logic [2:0]    len_q;
  logic          ilv_q;
  logic [GW-1:0] guard_q;
  logic          err_q;
  logic          legal;
  logic          unused_hi;

  assign legal     = len_legal(val_i[2:0], val_i[3]);
  assign unused_hi = ^val_i[MODE_W-1:4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q   <= LEN_1;
      ilv_q   <= 1'b0;
      guard_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (guard_q != '0) guard_q <= guard_q - 1'b1;
      if (load_i && guard_q == '0) begin
        if (idle_i && legal) begin
          len_q   <= val_i[2:0];
          ilv_q   <= val_i[3];
          guard_q <= GW'(GUARD_CYC);
          err_q   <= 1'b0;
        end else begin
          err_q <= 1'b1;
        end
      end
    end
  end

  assign len_o  = len_q;
  assign ilv_o  = ilv_q;
  assign busy_o = (guard_q != '0);
  assign err_o  = err_q;

  p_busy_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !idle_i) |=> ($stable(len_q) && $stable(ilv_q)));
  p_illegal_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy_o && !legal) |=> (err_q && $stable(len_q) && $stable(ilv_q)));
  p_guard_ignore_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(len_q) && $stable(ilv_q) && $stable(err_q)));
  p_legal_stored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> len_legal(len_q, ilv_q));
endmodule

// File: rtl/bseq_col_gen.sv
module bseq_col_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       len_i,
  input  logic             ilv_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             done_o
);
  import burst_seq_pkg::*;

  logic             active_q, ilv_q, page_q;
  logic [COL_W-1:0] base_q, cnt_q, mask_q, mask_n;
  logic [COL_W-1:0] low;
  logic             last;

  always_comb begin
    case (len_i)
      LEN_2:   mask_n = COL_W'(1);
      LEN_4:   mask_n = COL_W'(3);
      LEN_8:   mask_n = COL_W'(7);
      LEN_PAGE: mask_n = '1;
      default: mask_n = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ilv_q    <= 1'b0;
      page_q   <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      mask_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      ilv_q    <= ilv_i;
      page_q   <= (len_i == LEN_PAGE);
      base_q   <= col_i;
      cnt_q    <= '0;
      mask_q   <= mask_n;
    end else if (active_q) begin
      if (done_o) active_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // low bits step inside the aligned block; upper bits fixed from start column
  assign low     = ilv_q ? ((base_q ^ cnt_q) & mask_q) : ((base_q + cnt_q) & mask_q);
  assign col_o   = (base_q & ~mask_q) | low;
  assign last    = !page_q && (cnt_q == mask_q);
  assign valid_o = active_q;
  assign done_o  = active_q && (term_i || last);

  p_done_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> valid_o);
  p_term_ends_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !valid_o);
  p_page_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && page_q && !term_i && !start_i) |=> (col_o == $past(col_o) + 1'b1));
  p_block_fixed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !done_o && !start_i) |=> ((col_o & ~mask_q) == $past(col_o & ~mask_q)));
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W     = 8,
  parameter int MODE_W    = 11,
  parameter int GUARD_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_load_i,
  input  logic [MODE_W-1:0] mode_val_i,
  input  logic              banks_idle_i,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic              term_i,
  output logic [COL_W-1:0]  col_o,
  output logic              col_valid_o,
  output logic              burst_done_o,
  output logic              load_err_o
);
  logic [2:0] len;
  logic       ilv, busy, start_ok;

  bseq_mode_ctl #(.MODE_W(MODE_W), .GUARD_CYC(GUARD_CYC)) u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (mode_load_i),
    .val_i  (mode_val_i),
    .idle_i (banks_idle_i),
    .len_o  (len),
    .ilv_o  (ilv),
    .busy_o (busy),
    .err_o  (load_err_o)
  );

  assign start_ok = start_i && !busy;

  bseq_col_gen #(.COL_W(COL_W)) u_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_ok),
    .col_i   (start_col_i),
    .len_i   (len),
    .ilv_i   (ilv),
    .term_i  (term_i),
    .col_o   (col_o),
    .valid_o (col_valid_o),
    .done_o  (burst_done_o)
  );

  p_guard_no_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy && !col_valid_o) |=> !col_valid_o);
endmodule

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_load = 1'b0;
  logic [10:0] mode_val = '0;
  logic        banks_idle = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  start_col = '0;
  logic        term = 1'b0;
  logic [7:0]  col;
  logic        col_valid, burst_done, load_err;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  burst_col_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_load_i(mode_load), .mode_val_i(mode_val),
    .banks_idle_i(banks_idle), .start_i(start), .start_col_i(start_col), .term_i(term),
    .col_o(col), .col_valid_o(col_valid), .burst_done_o(burst_done), .load_err_o(load_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_col(input logic [7:0] s, input int k, input int bl, input logic ilv);
    logic [7:0] m, kk;
    kk = 8'(k);
    if (bl == 256) return s + kk;
    m = 8'(bl - 1);
    return (s & ~m) | (ilv ? ((s ^ kk) & m) : ((s + kk) & m));
  endfunction

  // drives a load at a falling edge; returns at the next falling edge
  task automatic do_load(input logic [10:0] v, input logic idle);
    mode_val = v; banks_idle = idle; mode_load = 1'b1;
    @(negedge clk);
    mode_load = 1'b0; banks_idle = 1'b1;
  endtask

  task automatic wait_guard();
    repeat (2) @(negedge clk);
  endtask

  // runs a burst; term_at < 0 means no terminate
  task automatic run_burst(input string req, input logic [7:0] s, input int bl,
                           input logic ilv, input int beats, input int term_at);
    start_col = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < beats; k++) begin
      if (k > 0) @(negedge clk);
      term = (k == term_at);
      #1;
      check({req, " col"}, col, exp_col(s, k, bl, ilv));
      check({req, " valid"}, col_valid, 1);
      check({req, " done"}, burst_done, (k == beats - 1) ? 1 : 0);
    end
    @(negedge clk);
    term = 1'b0;
    #1;
    check({req, " end valid"}, col_valid, 0);
  endtask

  task automatic t_reset();
    check("R1 valid", col_valid, 0);
    check("R1 done", burst_done, 0);
    check("R1 err", load_err, 0);
    run_burst("R1 default BL1", 8'h5A, 1, 1'b0, 1, -1);
  endtask

  task automatic t_seq();
    do_load(11'h7F3, 1'b1);  // BL8 seq, upper bits set (R2: no effect)
    check("R2 err clear", load_err, 0);
    wait_guard();
    run_burst("R6 seq BL8", 8'h2D, 8, 1'b0, 8, -1);
    run_burst("R10 seq BL8 aligned", 8'hF8, 8, 1'b0, 8, -1);
  endtask

  task automatic t_ilv();
    do_load(11'h00B, 1'b1);  // BL8 interleaved
    wait_guard();
    run_burst("R7 ilv BL8", 8'h2D, 8, 1'b1, 8, -1);
    do_load(11'h00A, 1'b1);  // BL4 interleaved
    wait_guard();
    run_burst("R7 ilv BL4", 8'h47, 4, 1'b1, 4, -1);
  endtask

  task automatic t_busy();
    do_load(11'h001, 1'b0);
    check("R3 err set", load_err, 1);
    run_burst("R3 mode kept", 8'h45, 4, 1'b1, 4, -1);
  endtask

  task automatic t_illegal();
    do_load(11'h004, 1'b1);
    check("R4 reserved err", load_err, 1);
    run_burst("R4 mode kept", 8'h12, 4, 1'b1, 4, -1);
    do_load(11'h00F, 1'b1);
    check("R4 page ilv err", load_err, 1);
    run_burst("R4 mode kept 2", 8'h33, 4, 1'b1, 4, -1);
  endtask

  task automatic t_guard();
    do_load(11'h001, 1'b1);  // BL2 seq accepted, err cleared
    check("R2 err cleared", load_err, 0);
    start_col = 8'h99; start = 1'b1;  // sampled inside guard
    @(negedge clk);
    start = 1'b0;
    #1;
    check("R5 start ignored", col_valid, 0);
    mode_val = 11'h004; mode_load = 1'b1;  // illegal load inside guard
    @(negedge clk);
    mode_load = 1'b0;
    #1;
    check("R5 start ignored 2", col_valid, 0);
    check("R5 load ignored err", load_err, 0);
    run_burst("R5 BL2 after guard", 8'h83, 2, 1'b0, 2, -1);
  endtask

  task automatic t_page();
    do_load(11'h007, 1'b1);
    wait_guard();
    run_burst("R8 page", 8'hFD, 256, 1'b0, 6, 5);
    run_burst("R8 page long", 8'h10, 256, 1'b0, 20, 19);
  endtask

  task automatic t_term();
    do_load(11'h003, 1'b1);
    wait_guard();
    run_burst("R9 term BL8", 8'h10, 8, 1'b0, 3, 2);
    run_burst("R9 term first", 8'h6E, 8, 1'b0, 1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seq();
    t_ilv();
    t_busy();
    t_illegal();
    t_guard();
    t_page();
    t_term();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule